// File: doc/BRIEF.md
# Partitioned SIMD Adder

This block is one wide integer adder/subtractor that can be cut into many narrow packed lanes. Two 256-bit operands arrive together with a lane-width code and an add/subtract select. The block splits its carry path at the chosen lane edges and applies the same operation to every lane in one cycle. Each lane's result wraps modulo 2^width, and each lane reports its carry-out in a 32-bit flag vector.

Internally the datapath is built from 32 byte-wide adder slices. A slice either takes the carry from the slice below it or starts a new lane. A new lane starts with a carry-in of 0 for add and 1 for subtract, and in subtract the B operand is inverted. A registered output stage holds the result and raises a valid strobe one cycle after an accepted request.

Top module: `simd_part_adder`

## Requirements
- R1: The `lane_mode` input selects the lane width as 0 = 8 bits (32 lanes), 1 = 16 bits (16 lanes), 2 = 32 bits (8 lanes) and 3 = 64 bits (4 lanes). Lane k occupies bits [k*w +: w] of every bus.
- R2: With `do_sub` = 0, every lane of `sum_out` equals (A lane + B lane) mod 2^w, and all lanes are computed in the same cycle.
- R3: With `do_sub` = 1, every lane of `sum_out` equals (A lane − B lane) mod 2^w.
- R4: No carry or borrow passes from one lane into the next. A lane that overflows leaves its upper neighbour unchanged.
- R5: Bit i of `lane_cout` is the carry-out of the lane whose most significant byte is byte i, so bit 8k+7 belongs to 64-bit lane k. For add it is 1 when A + B ≥ 2^w. For subtract it is 1 when A ≥ B unsigned, meaning no borrow.
- R6: Bits of `lane_cout` that are not at the top byte of a lane read 0.
- R7: `res_valid` rises one clock after a cycle in which `req_valid` is 1, and `sum_out` and `lane_cout` show that request's result in the same cycle.
- R8: In a cycle in which `req_valid` is 0, operand, mode and op changes have no effect. `res_valid` is 0 in the following cycle, and `sum_out` and `lane_cout` keep their last values.
- R9: While `rst_n` is low, `res_valid`, `sum_out` and `lane_cout` are cleared to 0 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operands, mode and op are valid this cycle |
| lane_mode | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64 bits) |
| do_sub | input | 1 | 0 = add, 1 = subtract (A − B) |
| opnd_a | input | 256 | Packed operand A |
| opnd_b | input | 256 | Packed operand B |
| res_valid | output | 1 | Result registers hold a fresh result |
| sum_out | output | 256 | Packed lane results |
| lane_cout | output | 32 | Per-lane carry-out, at each lane's top byte |

## Verification
The assertions assume that each request holds its mode, op and operands steady only for the cycle in which `req_valid` is high. They therefore compare the outputs with the `$past` values of the inputs from exactly one cycle earlier, and only when `res_valid` is set. They also assume that the lane code is always one of the four defined values, which the 2-bit port guarantees. The bench changes its inputs only on falling edges and pulses `req_valid` for a single cycle per request. Between requests it changes the operands while `req_valid` is low, which exercises the hold behaviour. Its stimulus covers all four lane codes with both operations, including all-ones, carry-into-neighbour and equal-operand patterns, and random operands checked against a lane-by-lane model.

// File: rtl/simd_pkg.sv
// Package: shared widths and the lane-width code for the partitioned adder.
// Assumes byte-granular slices; lane width in bytes is 2**code.
package simd_pkg;
    localparam int SLICE_W = 8;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/simd_lane_decode.sv
// Module: simd_lane_decode
// Turns the lane-width code into two per-slice masks. The first marks slices
// that begin a lane and the second marks slices that end one.
// Assumes NSLICE is a multiple of the widest lane (8 slices).
module simd_lane_decode #(
    parameter int NSLICE = 32
) (
    input  logic [simd_pkg::MODE_W-1:0] mode,
    output logic [NSLICE-1:0]           lane_start,
    output logic [NSLICE-1:0]           lane_top
);
    localparam int IDX_W = $clog2(NSLICE);

    logic [IDX_W-1:0] span_mask;

    // Slices per lane minus one: the index bits that vary inside a lane
    always_comb begin
        span_mask = IDX_W'((1 << mode) - 1);
    end

    for (genvar i = 0; i < NSLICE; i++) begin : g_mark
        localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
        // A slice starts a lane when its in-lane index bits are zero
        always_comb begin
            lane_start[i] = ((IDX & span_mask) == '0);
            lane_top[i]   = ((IDX & span_mask) == span_mask);
        end
    end
endmodule

// File: rtl/simd_byte_slice.sv
// Module: simd_byte_slice
// One slice of the wide adder: a plain ripple add of two slice operands
// and a carry-in. Operand inversion for subtract is done by the caller.
module simd_byte_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    // Slice sum with carry-out in the extra top bit
    always_comb begin
        {cout, s} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/simd_carry_chain.sv
// Module: simd_carry_chain
// Chains NSLICE byte slices into one wide adder. At each lane start the
// incoming carry is replaced by the op's injection bit (1 for subtract).
// Assumes lane_start[0] is always set by the decoder.
module simd_carry_chain #(
    parameter int DATA_W = 256,
    parameter int SW     = 8,
    localparam int NSLICE = DATA_W / SW
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [NSLICE-1:0] lane_start,
    input  logic [NSLICE-1:0] lane_top,
    output logic [DATA_W-1:0] sum,
    output logic [NSLICE-1:0] flags
);
    logic [DATA_W-1:0] b_eff;
    logic [NSLICE-1:0] cin;
    logic [NSLICE-1:0] cout;

    // Invert B for subtract; the +1 arrives as each lane's carry-in
    always_comb begin
        b_eff = b ^ {DATA_W{sub}};
    end

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        if (i == 0) begin : g_first
            // Lowest slice always opens a lane
            always_comb cin[i] = sub;
        end else begin : g_rest
            // Cut the chain at lane starts, otherwise ripple
            always_comb cin[i] = lane_start[i] ? sub : cout[i-1];
        end

        simd_byte_slice #(.W(SW)) u_slice (
            .a    (a[i*SW +: SW]),
            .b    (b_eff[i*SW +: SW]),
            .cin  (cin[i]),
            .s    (sum[i*SW +: SW]),
            .cout (cout[i])
        );
    end

    // Report carry-out only at lane tops
    always_comb begin
        flags = cout & lane_top;
    end
endmodule

// File: rtl/simd_out_stage.sv
// Module: simd_out_stage
// Optional result register. With REG_OUT = 1 it loads on in_vld and holds
// otherwise. With REG_OUT = 0 it passes the inputs through.
module simd_out_stage #(
    parameter int  DATA_W  = 256,
    parameter int  FLAG_W  = 32,
    parameter bit  REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_sum,
    input  logic [FLAG_W-1:0] in_flags,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_sum,
    output logic [FLAG_W-1:0] out_flags
);
    if (REG_OUT) begin : g_reg
        // Valid strobe: one cycle after each accepted request
        always_ff @(posedge clk) begin
            if (!rst_n) out_vld <= 1'b0;
            else        out_vld <= in_vld;
        end

        // Result registers: load on request, hold otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_sum   <= '0;
                out_flags <= '0;
            end else if (in_vld) begin
                out_sum   <= in_sum;
                out_flags <= in_flags;
            end
        end
    end else begin : g_comb
        // Pass-through variant
        always_comb begin
            out_vld   = in_vld;
            out_sum   = in_sum;
            out_flags = in_flags;
        end
    end
endmodule

// File: rtl/simd_part_adder.sv
// Module: simd_part_adder (top)
// A 256-bit add/subtract whose carry path is cut at 8/16/32/64-bit lane
// edges chosen by lane_mode. Results wrap, and per-lane carry-outs land
// at each lane's top byte. Assumes DATA_W is a multiple of 64.
module simd_part_adder #(
    parameter int DATA_W  = 256,
    parameter bit REG_OUT = 1'b1,
    localparam int NSLICE = DATA_W / simd_pkg::SLICE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [simd_pkg::MODE_W-1:0] lane_mode,
    input  logic                        do_sub,
    input  logic [DATA_W-1:0]           opnd_a,
    input  logic [DATA_W-1:0]           opnd_b,
    output logic                        res_valid,
    output logic [DATA_W-1:0]           sum_out,
    output logic [NSLICE-1:0]           lane_cout
);
    logic [NSLICE-1:0] start_m;
    logic [NSLICE-1:0] top_m;
    logic [DATA_W-1:0] sum_c;
    logic [NSLICE-1:0] flag_c;

    simd_lane_decode #(.NSLICE(NSLICE)) u_dec (
        .mode       (lane_mode),
        .lane_start (start_m),
        .lane_top   (top_m)
    );

    simd_carry_chain #(.DATA_W(DATA_W), .SW(simd_pkg::SLICE_W)) u_chain (
        .a          (opnd_a),
        .b          (opnd_b),
        .sub        (do_sub),
        .lane_start (start_m),
        .lane_top   (top_m),
        .sum        (sum_c),
        .flags      (flag_c)
    );

    simd_out_stage #(.DATA_W(DATA_W), .FLAG_W(NSLICE), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (req_valid),
        .in_sum    (sum_c),
        .in_flags  (flag_c),
        .out_vld   (res_valid),
        .out_sum   (sum_out),
        .out_flags (lane_cout)
    );
endmodule

// File: rtl/simd_part_adder_chk.sv
// Module: simd_part_adder_chk
// Port-level checks for the registered configuration, bound to the top.
module simd_part_adder_chk #(
    parameter int DATA_W = 256,
    parameter int NSLICE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        lane_mode,
    input logic              do_sub,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              res_valid,
    input logic [DATA_W-1:0] sum_out,
    input logic [NSLICE-1:0] lane_cout
);
    logic [NSLICE-1:0] top_ref;

    // Independent lane-top mask from the lane code
    always_comb begin
        for (int i = 0; i < NSLICE; i++)
            top_ref[i] = ((i % (1 << lane_mode)) == ((1 << lane_mode) - 1));
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(sum_out) && $stable(lane_cout)));

    // R6
    flag_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((lane_cout & ~$past(top_ref)) == '0));

    // R2
    add_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !do_sub && lane_mode == 2'd0)
        |=> sum_out[7:0] == $past(opnd_a[7:0] + opnd_b[7:0]));

    // R3
    sub_wide_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && do_sub && lane_mode == 2'd3)
        |=> sum_out[63:0] == $past(opnd_a[63:0] - opnd_b[63:0]));

    // R5
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !do_sub && lane_mode == 2'd0)
        |=> lane_cout[0] == $past(9'({1'b0, opnd_a[7:0]} + {1'b0, opnd_b[7:0]}) >> 8));
endmodule

bind simd_part_adder simd_part_adder_chk #(.DATA_W(DATA_W), .NSLICE(NSLICE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .lane_mode (lane_mode),
    .do_sub    (do_sub),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .res_valid (res_valid),
    .sum_out   (sum_out),
    .lane_cout (lane_cout)
);

// File: tb/simd_part_adder_tb.sv
module simd_part_adder_tb;
    localparam int DW = 256;
    localparam int NS = 32;

    typedef struct packed {
        logic [1:0]    mode;
        logic          sub;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] res;
        logic [NS-1:0] fl;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, {32{8'hFF}}, {32{8'h01}}, '0,                       32'hFFFFFFFF},
        '{2'd1, 1'b0, {32{8'hFF}}, {32{8'h01}}, {16{16'h0100}},           32'hAAAAAAAA},
        '{2'd2, 1'b0, {32{8'hFF}}, {32{8'h01}}, {8{32'h01010100}},        32'h88888888},
        '{2'd3, 1'b0, {32{8'hFF}}, {32{8'h01}}, {4{64'h0101010101010100}}, 32'h80808080},
        '{2'd2, 1'b0, {32{8'h12}}, {32{8'h34}}, {32{8'h46}},              32'h00000000},
        '{2'd0, 1'b0, {32{8'h80}}, {32{8'h80}}, '0,                       32'hFFFFFFFF},
        '{2'd1, 1'b0, {32{8'h80}}, {32{8'h80}}, {16{16'h0100}},           32'hAAAAAAAA},
        '{2'd0, 1'b1, {32{8'hFF}}, {32{8'h01}}, {32{8'hFE}},              32'hFFFFFFFF},
        '{2'd1, 1'b1, {32{8'h01}}, {32{8'h02}}, {16{16'hFEFF}},           32'h00000000},
        '{2'd3, 1'b1, {32{8'h01}}, {32{8'h02}}, {4{64'hFEFEFEFEFEFEFEFF}}, 32'h00000000},
        '{2'd3, 1'b1, {32{8'h5A}}, {32{8'h5A}}, '0,                       32'h80808080},
        '{2'd2, 1'b1, {32{8'h00}}, {32{8'h00}}, '0,                       32'h88888888}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    lane_mode = '0;
    logic          do_sub = 1'b0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic          res_valid;
    logic [DW-1:0] sum_out;
    logic [NS-1:0] lane_cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    simd_part_adder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .lane_mode (lane_mode),
        .do_sub    (do_sub),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .res_valid (res_valid),
        .sum_out   (sum_out),
        .lane_cout (lane_cout)
    );

    // Lane-by-lane reference model built from the requirements
    function automatic void ref_calc(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                     input logic [1:0] mode, input logic sub,
                                     output logic [DW-1:0] res, output logic [NS-1:0] fl);
        int w;
        logic [63:0] mask;
        logic [63:0] ea;
        logic [63:0] eb;
        logic [64:0] s;
        w = 8 << mode;
        mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        res = '0;
        fl = '0;
        for (int e = 0; e < DW / w; e++) begin
            ea = 64'(a >> (e * w)) & mask;
            eb = 64'(b >> (e * w)) & mask;
            if (sub) eb = ~eb & mask;
            s = {1'b0, ea} + {1'b0, eb} + 65'(sub);
            res = res | (DW'(s[63:0] & mask) << (e * w));
            fl[(e * w) / 8 + w / 8 - 1] = s[w];
        end
    endfunction

    task automatic check_out(input string req, input logic [DW-1:0] er,
                             input logic [NS-1:0] ef, input logic ev);
        checks++;
        if (sum_out !== er || lane_cout !== ef || res_valid !== ev) begin
            errors++;
            $display("FAIL %s: sum=%h flags=%h vld=%b expected sum=%h flags=%h vld=%b",
                     req, sum_out, lane_cout, res_valid, er, ef, ev);
        end
    endtask

    task automatic issue(input logic [1:0] m, input logic s,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        lane_mode = m; do_sub = s; opnd_a = a; opnd_b = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] er;
        logic [NS-1:0] ef;
        logic [DW-1:0] ra;
        logic [DW-1:0] rb;
        // R9: outputs cleared while in reset
        repeat (3) @(negedge clk);
        check_out("R9 reset", '0, '0, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].mode, VECS[i].sub, VECS[i].a, VECS[i].b);
            check_out($sformatf("R1/R2/R3/R4/R5/R6 vec %0d", i), VECS[i].res, VECS[i].fl, 1'b1);
        end

        // R4: lane 0 overflows into a zero neighbour in 8-bit mode
        issue(2'd0, 1'b0, {{30{8'h00}}, 8'h00, 8'hFF}, {{31{8'h00}}, 8'h01});
        check_out("R4 isolated carry", '0, 32'h00000001, 1'b1);

        // R2 R3 R5 R6: random operands for all codes and ops
        for (int n = 0; n < 64; n++) begin
            for (int k = 0; k < 8; k++) begin
                ra[k*32 +: 32] = $urandom;
                rb[k*32 +: 32] = $urandom;
            end
            ref_calc(ra, rb, 2'(n % 4), 1'((n / 4) % 2), er, ef);
            issue(2'(n % 4), 1'((n / 4) % 2), ra, rb);
            check_out($sformatf("R2/R3/R5/R6 random %0d", n), er, ef, 1'b1);
        end

        // R8: idle-cycle changes leave outputs unchanged
        @(negedge clk);
        lane_mode = 2'd1; do_sub = 1'b1; opnd_a = {32{8'hAA}}; opnd_b = {32{8'h55}};
        @(negedge clk);
        check_out("R8 hold", er, ef, 1'b0);
        @(negedge clk);
        check_out("R8 hold second", er, ef, 1'b0);

        // R7: valid only in the cycle after the request
        issue(2'd2, 1'b0, {32{8'h01}}, {32{8'h01}});
        check_out("R7 valid", {32{8'h02}}, '0, 1'b1);
        @(negedge clk);
        check_out("R7 valid drops", {32{8'h02}}, '0, 1'b0);

        // R9: mid-run reset clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R9 mid-run reset", '0, '0, 1'b0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule